// File: doc/BRIEF.md
# Upset Sensitivity Map Lookup Engine

This block classifies one configuration-memory upset at a time. It takes a 64-bit upset message and walks a compressed sensitivity map that sits in external memory. Each step reads one 32-bit word through a read master with a wait request and a separate read-data-valid strobe. The walk starts at a fixed header. From there it follows pointers through the per-sector descriptor, the sector's encoding scheme and the frame descriptor. It then reads a 16-bit tag index from the frame's encoding map and takes a packed variable-width tag from the frame's sensitivity data. Finally it reads a packed region bitmask.

A zero tag marks the upset bit as non-critical. A non-zero tag marks it critical and selects the region bitmask that is reported beside the result. Map pointers count 32-bit words. The block converts each word index into a byte address by multiplying it by four and adding the constant `START_ADDR`. A corrupt map signature raises a system error flag in place of a classification.

The message layout is fixed. In the upper 32-bit word, bits 23:16 hold the sector index. In the lower word, bits 23:12 hold the bit position inside the frame and bits 11:0 hold the frame index. All other bits are carried through untouched to the raw message output.

Top module: `upset_map_walker`

## Requirements
- R1: After reset, busy, critical, non-critical, system error, the region output and the raw message output are all zero, and no read is issued while busy is low.
- R2: Every read uses byte address `START_ADDR + 4*word_index`. Address and read strobe are held unchanged for as long as wait request is high.
- R3: The walk first reads header words 0, 1 and 2. Word 0 bits 27:0 must equal 0xE445341. On a mismatch the lookup ends after that one read with the system error flag set and neither critical nor non-critical set.
- R4: The encoding-scheme word 0 must carry 0xEEEE in bits 31:16. On a mismatch the lookup ends after 7 reads with the system error flag set and neither critical nor non-critical set.
- R5: A sector descriptor whose mask count (word 2 bits 23:8) is zero ends the lookup after 6 reads as non-critical with a zero region.
- R6: A tag index of 0xFFFF (phantom bit) ends the lookup after 11 reads as non-critical with a zero region. No further read is made.
- R7: A zero tag ends the lookup after 12 reads as non-critical with a zero region. Critical and non-critical are never high together.
- R8: A non-zero tag T ends the lookup after 13 reads as critical. The region output is the mask of header-size bits found at bit offset (T-1)*size after the word at sector-data address + 1.
- R9: Tags of width 1, 2, 4 and 8 are taken at bit offset tag_index*width from the frame data start, within little-endian bytes of little-endian words. Neighbouring tags do not leak into the result.
- R10: Busy rises on the edge that accepts a message, which clears all results. Busy falls on the same edge that sets critical, non-critical or system error. A message presented while busy is ignored.
- R11: A clear pulse zeroes critical, non-critical, the region output and the raw message output. It leaves the system error flag unchanged.
- R12: The sector index, frame index and bit position are taken from the message fields given above. The raw message output equals the accepted message once the result is set.
- R13: Region mask sizes from 1 to 32 bits are honoured. Bits of the word above the mask width are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Upset message present |
| msg_i | input | 64 | Upset message |
| clear_i | input | 1 | Clear last result |
| mem_read_o | output | 1 | Read strobe |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wait_i | input | 1 | Wait request, stalls the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Lookup in progress |
| critical_o | output | 1 | Upset bit is critical |
| noncritical_o | output | 1 | Upset bit is not critical |
| region_o | output | 32 | Affected region bitmask |
| msg_o | output | 64 | Raw message of the last result |
| sys_err_o | output | 1 | Map signature error |

## Verification
A wrong pointer or field register shows up as a read outside the built map, or as a read count that differs from the number fixed for each outcome. Either one is visible the moment busy falls. A wrong byte lane, shift or mask width shows up on the same edge as a flipped critical bit or a wrong region value. The map surrounds the target tag with all-ones neighbours and fills the other masks with decoys, so a one-position error cannot hide. Sequencing faults appear as busy and the result flags disagreeing on the completion edge.

// File: rtl/umw_pkg.sv
package umw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR0, ST_HDR1, ST_HDR2,
    ST_SI0, ST_SI1, ST_SI2,
    ST_ENC0, ST_ENC1, ST_ENC2,
    ST_FRM, ST_EMAP, ST_TAG, ST_MASK
  } walk_st_e;

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} port_st_e;

  localparam logic [27:0] HDR_SIG = 28'hE445341;
  localparam logic [15:0] ENC_ID  = 16'hEEEE;
  localparam logic [15:0] PHANTOM = 16'hFFFF;

  function automatic logic [31:0] low_ones(input logic [7:0] n);
    if (n >= 8'd32) return 32'hFFFF_FFFF;
    return (32'd1 << n) - 32'd1;
  endfunction
endpackage

// File: rtl/map_rd_port.sv
module map_rd_port #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [31:0] START_ADDR = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] word_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [31:0]       data_o,
  output logic              mem_read_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_wait_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i
);
  import umw_pkg::*;

  port_st_e st_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= P_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        P_IDLE: if (start_i) begin
          st_q   <= P_REQ;
          addr_q <= ADDR_W'(START_ADDR) + (word_i << 2);
        end
        P_REQ: if (!mem_wait_i) st_q <= P_RSP;
        P_RSP: if (mem_rvalid_i) st_q <= P_IDLE;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == P_IDLE);
  assign done_o     = (st_q == P_RSP) && mem_rvalid_i;
  assign data_o     = mem_rdata_i;
  assign mem_read_o = (st_q == P_REQ);
  assign mem_addr_o = addr_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_read_o && mem_wait_i) |=> (mem_read_o && $stable(mem_addr_o)));
  p_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_read_o |-> (mem_addr_o[1:0] == START_ADDR[1:0]));
endmodule

// File: rtl/tag_pick.sv
module tag_pick (
  input  logic [31:0] word_i,
  input  logic [1:0]  lane_i,
  input  logic [2:0]  shift_i,
  input  logic [7:0]  width_i,
  output logic [7:0]  tag_o
);
  import umw_pkg::*;
  logic [7:0] byte_sel;
  logic [31:0] wmask;

  always_comb begin
    unique case (lane_i)
      2'd0: byte_sel = word_i[7:0];
      2'd1: byte_sel = word_i[15:8];
      2'd2: byte_sel = word_i[23:16];
      default: byte_sel = word_i[31:24];
    endcase
    wmask = low_ones(width_i);
    tag_o = (byte_sel >> shift_i) & wmask[7:0];
  end
endmodule

// File: rtl/region_pick.sv
module region_pick (
  input  logic [31:0] word_i,
  input  logic [4:0]  shift_i,
  input  logic [7:0]  width_i,
  output logic [31:0] region_o
);
  import umw_pkg::*;
  assign region_o = (word_i >> shift_i) & low_ones(width_i);
endmodule

// File: rtl/upset_map_walker.sv
module upset_map_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [31:0] START_ADDR = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [63:0]       msg_i,
  input  logic              clear_i,
  output logic              mem_read_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_wait_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              critical_o,
  output logic              noncritical_o,
  output logic [31:0]       region_o,
  output logic [63:0]       msg_o,
  output logic              sys_err_o
);
  import umw_pkg::*;

  walk_st_e st_q;
  logic [63:0] msg_q;
  logic [7:0]  msize_q, tsize_q, tag_q;
  logic [31:0] sinfo_q, enc_q, sd_q, fadd_q, eadd_q;
  logic [15:0] nmask_q, mapsz_q, tidx_q;
  logic [11:0] mapidx_q;
  logic [19:0] foff_q;

  logic        rd_idle, rd_done, rd_start;
  logic [31:0] rd_data;
  logic [ADDR_W-1:0] word_addr;

  logic [7:0]  sector;
  logic [11:0] bitpos, frame;
  logic [31:0] l_words, fd_word, tag_bits, emap_off, moff;
  logic [15:0] tidx_rd;
  logic [7:0]  tag_rd;
  logic [31:0] region_rd;

  assign sector = msg_q[55:48];
  assign bitpos = msg_q[23:12];
  assign frame  = msg_q[11:0];

  // offsets derived from captured fields
  assign l_words  = (32'(nmask_q) * 32'(msize_q) + 32'd31) >> 5;
  assign fd_word  = sd_q + 32'd1 + l_words + 32'(foff_q) * 32'(tsize_q);
  assign tag_bits = 32'(tidx_q) * 32'(tsize_q);
  assign emap_off = 32'(mapidx_q) * 32'(mapsz_q) + (32'(bitpos) << 1);
  assign moff     = (32'(tag_q) - 32'd1) * 32'(msize_q);
  assign tidx_rd  = emap_off[1] ? rd_data[31:16] : rd_data[15:0];

  always_comb begin
    unique case (st_q)
      ST_HDR0: word_addr = ADDR_W'(0);
      ST_HDR1: word_addr = ADDR_W'(1);
      ST_HDR2: word_addr = ADDR_W'(2);
      ST_SI0:  word_addr = ADDR_W'(sinfo_q + 32'(sector) * 32'd3);
      ST_SI1:  word_addr = ADDR_W'(sinfo_q + 32'(sector) * 32'd3 + 32'd1);
      ST_SI2:  word_addr = ADDR_W'(sinfo_q + 32'(sector) * 32'd3 + 32'd2);
      ST_ENC0: word_addr = ADDR_W'(enc_q);
      ST_ENC1: word_addr = ADDR_W'(enc_q + 32'd1);
      ST_ENC2: word_addr = ADDR_W'(enc_q + 32'd2);
      ST_FRM:  word_addr = ADDR_W'(enc_q + fadd_q + 32'(frame));
      ST_EMAP: word_addr = ADDR_W'(enc_q + eadd_q + (emap_off >> 2));
      ST_TAG:  word_addr = ADDR_W'(fd_word + (tag_bits >> 5));
      ST_MASK: word_addr = ADDR_W'(sd_q + 32'd1 + (moff >> 5));
      default: word_addr = '0;
    endcase
  end

  assign rd_start = (st_q != ST_IDLE) && rd_idle;

  map_rd_port #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_port (
    .clk_i, .rst_ni,
    .start_i(rd_start), .word_i(word_addr),
    .idle_o(rd_idle), .done_o(rd_done), .data_o(rd_data),
    .mem_read_o, .mem_addr_o, .mem_wait_i, .mem_rvalid_i, .mem_rdata_i
  );

  tag_pick u_tag (
    .word_i(rd_data), .lane_i(tag_bits[4:3]), .shift_i(tag_bits[2:0]),
    .width_i(tsize_q), .tag_o(tag_rd)
  );

  region_pick u_region (
    .word_i(rd_data), .shift_i(moff[4:0]), .width_i(msize_q),
    .region_o(region_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      msg_q <= '0; msize_q <= '0; tsize_q <= '0; tag_q <= '0;
      sinfo_q <= '0; enc_q <= '0; sd_q <= '0; fadd_q <= '0; eadd_q <= '0;
      nmask_q <= '0; mapsz_q <= '0; tidx_q <= '0; mapidx_q <= '0; foff_q <= '0;
      critical_o <= 1'b0; noncritical_o <= 1'b0; region_o <= '0;
      msg_o <= '0; sys_err_o <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (msg_valid_i) begin
        st_q <= ST_HDR0;
        msg_q <= msg_i;
        critical_o <= 1'b0; noncritical_o <= 1'b0; region_o <= '0;
        msg_o <= '0; sys_err_o <= 1'b0;
      end else if (clear_i) begin
        critical_o <= 1'b0; noncritical_o <= 1'b0; region_o <= '0;
        msg_o <= '0;
      end
    end else if (rd_done) begin
      unique case (st_q)
        ST_HDR0: if (rd_data[27:0] == HDR_SIG) st_q <= ST_HDR1;
                 else begin st_q <= ST_IDLE; sys_err_o <= 1'b1; msg_o <= msg_q; end
        ST_HDR1: begin msize_q <= rd_data[7:0]; st_q <= ST_HDR2; end
        ST_HDR2: begin sinfo_q <= rd_data; st_q <= ST_SI0; end
        ST_SI0:  begin enc_q <= rd_data; st_q <= ST_SI1; end
        ST_SI1:  begin sd_q <= rd_data; st_q <= ST_SI2; end
        ST_SI2: begin
          nmask_q <= rd_data[23:8];
          tsize_q <= rd_data[7:0];
          if (rd_data[23:8] == 16'd0) begin
            st_q <= ST_IDLE; noncritical_o <= 1'b1; msg_o <= msg_q;
          end else st_q <= ST_ENC0;
        end
        ST_ENC0: if (rd_data[31:16] == ENC_ID) begin
                   mapsz_q <= rd_data[15:0]; st_q <= ST_ENC1;
                 end else begin st_q <= ST_IDLE; sys_err_o <= 1'b1; msg_o <= msg_q; end
        ST_ENC1: begin fadd_q <= rd_data; st_q <= ST_ENC2; end
        ST_ENC2: begin eadd_q <= rd_data; st_q <= ST_FRM; end
        ST_FRM: begin
          mapidx_q <= rd_data[31:20];
          foff_q   <= rd_data[19:0];
          st_q     <= ST_EMAP;
        end
        ST_EMAP: begin
          tidx_q <= tidx_rd;
          if (tidx_rd == PHANTOM) begin
            st_q <= ST_IDLE; noncritical_o <= 1'b1; msg_o <= msg_q;
          end else st_q <= ST_TAG;
        end
        ST_TAG: begin
          tag_q <= tag_rd;
          if (tag_rd == 8'd0) begin
            st_q <= ST_IDLE; noncritical_o <= 1'b1; msg_o <= msg_q;
          end else st_q <= ST_MASK;
        end
        ST_MASK: begin
          st_q <= ST_IDLE; critical_o <= 1'b1; region_o <= region_rd; msg_o <= msg_q;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_read_o);
  p_sys_err_no_class_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_err_o |-> (!critical_o && !noncritical_o));
  p_class_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(critical_o && noncritical_o));
  p_noncrit_region_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noncritical_o |-> (region_o == '0));
  p_busy_fall_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (critical_o || noncritical_o || sys_err_o));
  p_busy_rise_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!critical_o && !noncritical_o && !sys_err_o && region_o == '0));
  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rd_done) |=> $stable(msg_q));
endmodule

// File: tb/upset_map_walker_tb.sv
module upset_map_walker_tb;
  localparam logic [31:0] START = 32'h0000_0400;
  localparam int SECT = 2, FRAME = 3, BITPOS = 5, FOFF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0, clear = 1'b0;
  logic [63:0] msg = '0;
  logic mem_read, mem_wait = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic busy, crit, noncrit, sys_err;
  logic [31:0] region;
  logic [63:0] msg_out;

  int checks = 0, failures = 0, cyc = 0, rd_cnt = 0;
  logic addr_bad = 1'b0, hold_bad = 1'b0;
  logic [31:0] mem [0:255];
  logic [7:0] lfsr = 8'h5B;
  logic pend = 1'b0, dly = 1'b0;
  logic [7:0] ridx = '0;
  logic prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  always #2 clk = ~clk;

  upset_map_walker #(.ADDR_W(32), .START_ADDR(START)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_i(msg),
    .clear_i(clear), .mem_read_o(mem_read), .mem_addr_o(mem_addr),
    .mem_wait_i(mem_wait), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .critical_o(crit), .noncritical_o(noncrit),
    .region_o(region), .msg_o(msg_out), .sys_err_o(sys_err)
  );

  // memory model: random stalls and 1..2 cycle response latency
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_wait <= lfsr[0] & lfsr[2];
    mem_rvalid <= 1'b0;
    if (prev_stall && (!mem_read || mem_addr != prev_addr)) hold_bad <= 1'b1;
    prev_stall <= mem_read && mem_wait;
    prev_addr <= mem_addr;
    if (pend) begin
      if (!dly) begin
        mem_rvalid <= 1'b1; mem_rdata <= mem[ridx]; pend <= 1'b0;
      end else dly <= 1'b0;
    end else if (mem_read && !mem_wait) begin
      rd_cnt <= rd_cnt + 1;
      if (mem_addr < START || mem_addr[1:0] != 2'b00 || (mem_addr - START) >= 32'd1024)
        addr_bad <= 1'b1;
      ridx <= 8'((mem_addr - START) >> 2);
      pend <= 1'b1; dly <= lfsr[1];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ones(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] decoy(input int r);
    return 32'h5AC3_96E1 ^ (32'(r) * 32'h1357_9BDF);
  endfunction

  function automatic logic [63:0] mk_msg(input int sect, input int frm, input int bp);
    return {8'h00, 8'(sect), 16'h0, 3'b001, 1'b1, 4'h0, 12'(bp), 12'(frm)};
  endfunction

  task automatic put_bits(input int base, input int off, input logic [31:0] val);
    mem[base + off / 32] = mem[base + off / 32] | (val << (off % 32));
  endtask

  // Build a map: header, sector 2 info, encoding at word 64, data at 128
  task automatic build(input int ms, input int nm, input int ts, input int tidx, input int tag);
    int l, fd;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0] = 32'h1E44_5341;
    mem[1] = 32'(ms);
    mem[2] = 32'd16;
    mem[16 + SECT * 3]     = 32'd64;
    mem[16 + SECT * 3 + 1] = 32'd128;
    mem[16 + SECT * 3 + 2] = {8'h0, 16'(nm), 8'(ts)};
    mem[64] = {16'hEEEE, 16'd32};
    mem[65] = 32'd4;
    mem[66] = 32'd8;
    mem[64 + 4 + FRAME] = {12'd1, 20'(FOFF)};
    // entry byte offset 1*32 + 5*2 = 42: word 72+10, upper half
    mem[82] = {16'(tidx), 16'h1234};
    mem[128] = 32'hDDDD_0000;
    for (int r = 0; r < nm; r++) put_bits(129, r * ms, decoy(r) & ones(ms));
    l = (nm * ms + 31) / 32;
    fd = 129 + l + FOFF * ts;
    if (tidx != 16'hFFFF) begin
      put_bits(fd, tidx * ts, 32'(tag) & ones(ts));
      if (tidx > 0) put_bits(fd, (tidx - 1) * ts, ones(ts));
      put_bits(fd, (tidx + 1) * ts, ones(ts));
    end
  endtask

  task automatic send(input logic [63:0] m);
    @(negedge clk); msg_valid = 1'b1; msg = m;
    @(negedge clk); msg_valid = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [63:0] m, input int nreads,
                        input logic ec, input logic en, input logic [31:0] er, input logic ee);
    int base, n;
    base = rd_cnt;
    send(m);
    chk({req, " R10 busy rises"}, busy, 1'b1);
    n = 0;
    while (busy && n < 5000) begin
      if (crit || noncrit || sys_err) chk({req, " R10 early result"}, 1'b1, 1'b0);
      @(negedge clk); n++;
    end
    chk({req, " critical"}, crit, ec);
    chk({req, " noncritical"}, noncrit, en);
    chk({req, " region"}, region, er);
    chk({req, " sys_err"}, sys_err, ee);
    chk({req, " read count"}, rd_cnt - base, nreads);
    chk({req, " R12 raw msg"}, msg_out, m);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 1'b0);
    chk("R1 outputs", {crit, noncrit, sys_err, region, mem_read}, '0);
    chk("R1 msg", msg_out, '0);
  endtask

  task automatic t_critical;
    build(8, 5, 4, 7, 3);
    lookup("R8 crit", mk_msg(SECT, FRAME, BITPOS), 13, 1, 0, decoy(2) & ones(8), 0);
  endtask

  task automatic t_tag_sizes;
    build(4, 3, 1, 37, 1);
    lookup("R9 ts1", mk_msg(SECT, FRAME, BITPOS), 13, 1, 0, decoy(0) & ones(4), 0);
    build(4, 3, 2, 13, 2);
    lookup("R9 ts2", mk_msg(SECT, FRAME, BITPOS), 13, 1, 0, decoy(1) & ones(4), 0);
    build(4, 5, 8, 5, 4);
    lookup("R9 ts8", mk_msg(SECT, FRAME, BITPOS), 13, 1, 0, decoy(3) & ones(4), 0);
  endtask

  task automatic t_mask_sizes;
    build(32, 3, 2, 3, 3);
    lookup("R13 ms32", mk_msg(SECT, FRAME, BITPOS), 13, 1, 0, decoy(2), 0);
    build(1, 6, 4, 9, 6);
    lookup("R13 ms1", mk_msg(SECT, FRAME, BITPOS), 13, 1, 0, decoy(5) & 32'h1, 0);
  endtask

  task automatic t_zero_tag;
    build(8, 4, 4, 6, 0);
    lookup("R7 zero tag", mk_msg(SECT, FRAME, BITPOS), 12, 0, 1, 32'h0, 0);
  endtask

  task automatic t_phantom;
    build(8, 4, 4, 16'hFFFF, 0);
    lookup("R6 phantom", mk_msg(SECT, FRAME, BITPOS), 11, 0, 1, 32'h0, 0);
  endtask

  task automatic t_empty_sector;
    build(8, 0, 4, 6, 2);
    lookup("R5 empty", mk_msg(SECT, FRAME, BITPOS), 6, 0, 1, 32'h0, 0);
  endtask

  task automatic t_bad_sig;
    build(8, 4, 4, 6, 2);
    mem[0] = 32'h1E44_5340;
    lookup("R3 bad sig", mk_msg(SECT, FRAME, BITPOS), 1, 0, 0, 32'h0, 1);
  endtask

  task automatic t_bad_enc;
    build(8, 4, 4, 6, 2);
    mem[64] = {16'hEEEF, 16'd32};
    lookup("R4 bad id", mk_msg(SECT, FRAME, BITPOS), 7, 0, 0, 32'h0, 1);
  endtask

  task automatic t_busy_ignore;
    logic [63:0] a;
    int base, n;
    build(8, 5, 4, 7, 3);
    a = mk_msg(SECT, FRAME, BITPOS);
    base = rd_cnt;
    send(a);
    send(mk_msg(0, 1, 1));
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk("R10 ignored msg raw", msg_out, a);
    chk("R10 ignored msg crit", crit, 1'b1);
    chk("R10 ignored msg reads", rd_cnt - base, 13);
    repeat (3) @(negedge clk);
    chk("R10 no restart", busy, 1'b0);
  endtask

  task automatic t_clear;
    t_critical;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk("R11 clear result", {crit, noncrit, region}, '0);
    chk("R11 clear msg", msg_out, '0);
    t_bad_sig;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk("R11 sys_err kept", sys_err, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_critical;
    t_tag_sizes;
    t_mask_sizes;
    t_zero_tag;
    t_phantom;
    t_empty_sector;
    t_bad_sig;
    t_bad_enc;
    t_busy_ignore;
    t_clear;
    chk("R2 address range", addr_bad, 1'b0);
    chk("R2 hold under wait", hold_bad, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule